// File: doc/BRIEF.md
# Bus Error Capture Register File

This block holds four 32-bit status registers. Together they record why a memory access failed and at which virtual byte address it failed. Software reaches the registers through a plain register port: a 2-bit index, a write strobe with 32-bit data, and a read strobe. Every read is destructive. The value leaves on the read data bus and the register drops to zero at the same clock edge. Each register shapes software writes in its own way. Slot 0 keeps the low byte and forces its write marker bit. Slot 1 takes the value as written. Slot 2 keeps only its mask bits. Slot 3 copies data bit 29 into bits 30 and 31.

The translation logic reports faults on a separate one-cycle strobe. Each report carries a kind code, a read/write flag and the faulting address. A report updates slot 0 and slot 1 and raises a one-cycle memory-access-error pulse toward the processor. The fault strobe has no back-pressure: every pulse is accepted in the cycle it is presented. The register port also has no handshake. A strobe is one access, and read data appears on the cycle after the read strobe.

Top module: `fault_status_bank`

## Requirements
- R1: After reset all four registers read as zero, `mem_err` is low and `reg_rdata` is zero.
- R2: A read strobe drives the addressed register's value onto `reg_rdata` one cycle later and clears that register at the same edge, so a second read returns zero. `reg_rdata` holds its value until the next read.
- R3: A write to slot 0 stores data bits 7:0, sets bit 15 and clears every other bit.
- R4: A write to slot 1 stores all 32 bits unchanged. A write to slot 2 stores only data bits 7, 5 and 4 (mask 0xB0).
- R5: A write to slot 3 stores data bits 29:0 and sets both bit 30 and bit 31 equal to data bit 29.
- R6: A fault with `flt_kind`=0 (invalid page entry) ORs 0x80 into slot 0. On a read (`flt_write`=0) it also clears bit 15. On a write it ORs 0x8080 into slot 0.
- R7: A fault with `flt_kind`=1 (undefined memory type) overwrites slot 0 with 0x20 on a read and with 0x8020 on a write.
- R8: Every fault loads slot 1 with `flt_vaddr`. It also drives `mem_err` high for exactly the one cycle after the fault strobe.
- R9: When several events hit one slot in the same cycle, they apply in this order: the read clear, then the software write, then the fault update on top of the result. The read still returns the value held before that edge.
- R10: The slot is chosen by `reg_idx` (0 to 3). An access changes no other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_idx | input | 2 | Register slot for the read or write |
| reg_wr_en | input | 1 | Software write strobe |
| reg_wdata | input | 32 | Software write data |
| reg_rd_en | input | 1 | Destructive read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd_en` |
| flt_valid | input | 1 | Fault report strobe, one cycle per fault |
| flt_kind | input | 1 | 0 = invalid page entry, 1 = undefined memory type |
| flt_write | input | 1 | 1 when the faulting access was a write |
| flt_vaddr | input | 32 | Faulting virtual byte address |
| mem_err | output | 1 | Memory-access-error pulse to the processor |

## Verification
Register updates take effect at the edge that samples the strobe. Read data and `mem_err` appear one register stage later, so both are due exactly one cycle after their stimulus. The bench drives all strobes on the falling edge and samples on the next falling edge. Each sample therefore falls half a period after the rising edge that produced the result. The pulse check samples `mem_err` on two falling edges in a row: it must be high on the first and low on the second. Register contents are only ever seen through destructive reads, so each scenario reads a slot once for its value and, where R2 matters, a second time to confirm it was cleared.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);

  // fault kind code carried on flt_kind
  typedef enum logic {
    FLT_BAD_ENTRY = 1'b0,
    FLT_BAD_TYPE  = 1'b1
  } flt_kind_e;

  localparam logic [DATA_W-1:0] S0_KEEP      = 32'h0000_00FF;
  localparam logic [DATA_W-1:0] S0_WR_MARK   = 32'h0000_8000;
  localparam logic [DATA_W-1:0] S2_KEEP      = 32'h0000_00B0;
  localparam logic [DATA_W-1:0] S3_KEEP      = 32'h3FFF_FFFF;
  localparam int unsigned       S3_SRC_BIT   = 29;
  localparam logic [DATA_W-1:0] BAD_ENTRY_BIT = 32'h0000_0080;
  localparam logic [DATA_W-1:0] BAD_TYPE_CODE = 32'h0000_0020;
endpackage

// File: rtl/fsb_wr_shape.sv
module fsb_wr_shape
  import fsb_pkg::*;
#(
  parameter int unsigned SLOT = 0
) (
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] shaped_o
);
  generate
    if (SLOT == 0) begin : g_s0
      assign shaped_o = (wdata_i & S0_KEEP) | S0_WR_MARK;
    end else if (SLOT == 2) begin : g_s2
      assign shaped_o = wdata_i & S2_KEEP;
    end else if (SLOT == 3) begin : g_s3
      assign shaped_o = (wdata_i & S3_KEEP)
                      | {{2{wdata_i[S3_SRC_BIT]}}, {(DATA_W-2){1'b0}}};
    end else begin : g_pass
      assign shaped_o = wdata_i;
    end
  endgenerate
endmodule

// File: rtl/fsb_fault_merge.sv
module fsb_fault_merge
  import fsb_pkg::*;
(
  input  logic [DATA_W-1:0] base_i,
  input  logic              kind_i,
  input  logic              is_write_i,
  output logic [DATA_W-1:0] merged_o
);
  always_comb begin
    if (flt_kind_e'(kind_i) == FLT_BAD_TYPE) begin
      merged_o = BAD_TYPE_CODE | (is_write_i ? S0_WR_MARK : '0);
    end else if (is_write_i) begin
      merged_o = base_i | BAD_ENTRY_BIT | S0_WR_MARK;
    end else begin
      merged_o = (base_i | BAD_ENTRY_BIT) & ~S0_WR_MARK;
    end
  end
endmodule

// File: rtl/fault_status_bank.sv
module fault_status_bank
  import fsb_pkg::*;
#(
  parameter int unsigned VA_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_idx,
  input  logic             reg_wr_en,
  input  logic [31:0]      reg_wdata,
  input  logic             reg_rd_en,
  output logic [31:0]      reg_rdata,
  input  logic             flt_valid,
  input  logic             flt_kind,
  input  logic             flt_write,
  input  logic [VA_W-1:0]  flt_vaddr,
  output logic             mem_err
);
  logic [DATA_W-1:0] stat_q [NUM_REGS];
  logic [DATA_W-1:0] stat_d [NUM_REGS];
  logic [DATA_W-1:0] shaped [NUM_REGS];
  logic [DATA_W-1:0] base   [NUM_REGS];
  logic [DATA_W-1:0] slot0_fault;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_shape
      fsb_wr_shape #(.SLOT(g)) u_shape (
        .wdata_i (reg_wdata),
        .shaped_o(shaped[g])
      );
    end
  endgenerate

  fsb_fault_merge u_merge (
    .base_i    (base[0]),
    .kind_i    (flt_kind),
    .is_write_i(flt_write),
    .merged_o  (slot0_fault)
  );

  // order per slot: read clear, then software write, then fault
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      base[i] = stat_q[i];
      if (reg_rd_en && reg_idx == IDX_W'(i)) base[i] = '0;
      if (reg_wr_en && reg_idx == IDX_W'(i)) base[i] = shaped[i];
      stat_d[i] = base[i];
    end
    if (flt_valid) begin
      stat_d[0] = slot0_fault;
      stat_d[1] = DATA_W'(flt_vaddr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) stat_q[i] <= '0;
      reg_rdata <= '0;
      mem_err   <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) stat_q[i] <= stat_d[i];
      if (reg_rd_en) reg_rdata <= stat_q[reg_idx];
      mem_err <= flt_valid;
    end
  end

  AST_ERR_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> mem_err); // R8
  AST_ERR_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_err |-> $past(flt_valid)); // R8
  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> stat_q[1] == DATA_W'($past(flt_vaddr))); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && !reg_wr_en && !flt_valid) |=> stat_q[$past(reg_idx)] == '0); // R2
  AST_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rdata == $past(stat_q[reg_idx])); // R2
  AST_SLOT2_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[2] & ~S2_KEEP) == '0); // R4
  AST_SLOT3_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[3][31] == stat_q[3][29] && stat_q[3][30] == stat_q[3][29]); // R5
  AST_TYPE_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_kind) |=> (stat_q[0] & ~S0_WR_MARK) == BAD_TYPE_CODE); // R7
endmodule

// File: tb/test_fault_status_bank.sv
module test_fault_status_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd_en = 1'b0;
  logic [31:0] reg_rdata;
  logic        flt_valid = 1'b0;
  logic        flt_kind = 1'b0;
  logic        flt_write = 1'b0;
  logic [31:0] flt_vaddr = '0;
  logic        mem_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk; // 250 MHz

  fault_status_bank i_fault_status_bank (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata),
    .flt_valid(flt_valid), .flt_kind(flt_kind), .flt_write(flt_write),
    .flt_vaddr(flt_vaddr), .mem_err(mem_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_idx = idx; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] idx, input logic [31:0] exp);
    logic [31:0] v;
    rd(idx, v);
    check(req, v, exp);
  endtask

  task automatic fault(input logic kind, input logic w, input logic [31:0] a);
    @(negedge clk);
    flt_valid = 1'b1; flt_kind = kind; flt_write = w; flt_vaddr = a;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 mem_err", {31'b0, mem_err}, 32'h0);
    check("R1 rdata", reg_rdata, 32'h0);
    for (int i = 0; i < 4; i++) rd_chk("R1 slot", 2'(i), 32'h0);
  endtask

  task automatic t_slot_writes;
    wr(2'd0, 32'hFFFF_FF5A);
    rd_chk("R3 slot0 shape", 2'd0, 32'h0000_805A);
    rd_chk("R2 read clears", 2'd0, 32'h0);
    wr(2'd1, 32'hDEAD_BEEF);
    rd_chk("R4 slot1 full", 2'd1, 32'hDEAD_BEEF);
    wr(2'd2, 32'hFFFF_FFFF);
    rd_chk("R4 slot2 mask", 2'd2, 32'h0000_00B0);
    wr(2'd2, 32'h0000_004F);
    rd_chk("R4 slot2 none", 2'd2, 32'h0);
    wr(2'd3, 32'h2000_0001);
    rd_chk("R5 slot3 bit29 set", 2'd3, 32'hE000_0001);
    wr(2'd3, 32'hDFFF_FFFF);
    rd_chk("R5 slot3 bit29 clr", 2'd3, 32'h1FFF_FFFF);
  endtask

  task automatic t_isolation;
    wr(2'd3, 32'h0000_1234);
    wr(2'd1, 32'h0000_00AA);
    rd_chk("R10 slot0 untouched", 2'd0, 32'h0);
    rd_chk("R10 slot2 untouched", 2'd2, 32'h0);
    rd_chk("R10 slot3 kept", 2'd3, 32'h0000_1234);
    rd_chk("R10 slot1 kept", 2'd1, 32'h0000_00AA);
  endtask

  task automatic t_bad_entry;
    wr(2'd0, 32'h0000_0001);
    fault(1'b0, 1'b0, 32'h0000_1000);
    rd_chk("R6 entry read", 2'd0, 32'h0000_0081);
    wr(2'd0, 32'h0000_0000);
    fault(1'b0, 1'b1, 32'h0000_2000);
    rd_chk("R6 entry write", 2'd0, 32'h0000_8080);
    fault(1'b0, 1'b0, 32'h0000_3000);
    rd_chk("R6 entry read from zero", 2'd0, 32'h0000_0080);
  endtask

  task automatic t_bad_type;
    wr(2'd0, 32'h0000_00FF);
    fault(1'b1, 1'b0, 32'h0000_4000);
    rd_chk("R7 type read", 2'd0, 32'h0000_0020);
    wr(2'd0, 32'h0000_0007);
    fault(1'b1, 1'b1, 32'h0000_5000);
    rd_chk("R7 type write", 2'd0, 32'h0000_8020);
  endtask

  task automatic t_pulse_addr;
    @(negedge clk);
    flt_valid = 1'b1; flt_kind = 1'b1; flt_write = 1'b0; flt_vaddr = 32'h1234_5678;
    @(negedge clk);
    flt_valid = 1'b0;
    check("R8 mem_err high", {31'b0, mem_err}, 32'h1);
    @(negedge clk);
    check("R8 mem_err low", {31'b0, mem_err}, 32'h0);
    rd_chk("R8 vaddr captured", 2'd1, 32'h1234_5678);
    rd_chk("R2 rdata after clear", 2'd1, 32'h0);
  endtask

  task automatic t_collisions;
    logic [31:0] v;
    // write and fault on slot 1 together: fault address wins
    @(negedge clk);
    reg_idx = 2'd1; reg_wdata = 32'h0000_AAAA; reg_wr_en = 1'b1;
    flt_valid = 1'b1; flt_kind = 1'b1; flt_write = 1'b1; flt_vaddr = 32'h0000_5555;
    @(negedge clk);
    reg_wr_en = 1'b0; flt_valid = 1'b0;
    rd_chk("R9 fault beats write", 2'd1, 32'h0000_5555);
    // slot0 now 0x8020: read while an entry-read fault lands
    @(negedge clk);
    reg_idx = 2'd0; reg_rd_en = 1'b1;
    flt_valid = 1'b1; flt_kind = 1'b0; flt_write = 1'b0; flt_vaddr = 32'h0000_6000;
    @(negedge clk);
    reg_rd_en = 1'b0; flt_valid = 1'b0;
    check("R9 read returns old", reg_rdata, 32'h0000_8020);
    rd_chk("R9 fault after clear", 2'd0, 32'h0000_0080);
    // write to slot0 with entry-write fault in the same cycle
    @(negedge clk);
    reg_idx = 2'd0; reg_wdata = 32'h0000_0011; reg_wr_en = 1'b1;
    flt_valid = 1'b1; flt_kind = 1'b0; flt_write = 1'b1; flt_vaddr = 32'h0000_7000;
    @(negedge clk);
    reg_wr_en = 1'b0; flt_valid = 1'b0;
    rd(2'd0, v);
    check("R9 fault on written", v, 32'h0000_8091);
    check("R2 rdata held", reg_rdata, 32'h0000_8091);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slot_writes();
    t_isolation();
    t_bad_entry();
    t_bad_type();
    t_pulse_addr();
    t_collisions();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule